// File: doc/BRIEF.md
# Viewport-Windowed PCIe Address Translator

This block holds two banks of translation regions, one for outbound traffic and one for inbound traffic, with four regions in each bank by default. Software reaches the region registers through a single viewport: it first writes a selector that picks a bank and a region index. After that, one shared set of windowed offsets reads and writes only the region that the selector names. The host side is a plain 32-bit register port with a write strobe and a read strobe. Read data appears one cycle after the read strobe.

The outbound translation port takes a 64-bit local address. It compares the address against the enabled outbound windows and returns, one cycle later, the translated bus address, the region's transaction kind and a hit flag. The inbound port takes the index of the BAR that a request hit. It returns, one cycle later, the local target address programmed for that BAR and a hit flag. Configuration-kind regions carry bus, device and function in target bits 31:24, 23:19 and 18:16. The block passes these bits through as part of the target value.

Top module: `atu_window`

## Requirements
- R1: After a synchronous reset every region is disabled and every register reads 0. Outputs `ob_hit`, `ib_hit`, `ib_local_addr` and `reg_rdata` are 0.
- R2: The selector lives at offset 0x900. Bit 31 picks the bank (1 = inbound, 0 = outbound) and bits 1:0 give the region index. A read returns bit 31, bits 1:0, and 0 in all other bits.
- R3: Offsets 0x904 to 0x91C act only on the selected region of the selected bank, and a read returns that region's contents. The offsets are: 0x904 kind (bits 2:0); 0x908 control (bit 31 enable, bit 30 BAR-match, bits 10:8 BAR number, all other bits read 0); 0x90C base low; 0x910 base high; 0x914 limit low; 0x918 target low; 0x91C target high. Regions that are not selected keep their contents.
- R4: An outbound address A hits an enabled outbound region when base ≤ A ≤ {base high, limit}. One cycle later `ob_bus_addr` = target + (A − base), `ob_kind` is the region's kind and `ob_hit` = 1.
- R5: The window is inclusive at both ends. The base and the limit hit; base − 1 and limit + 1 miss.
- R6: On an outbound miss, `ob_hit` = 0, `ob_bus_addr` equals the input address of the previous cycle, and `ob_kind` = 0 (memory).
- R7: When several enabled outbound regions match, the lowest index wins.
- R8: A region whose enable bit is 0 never matches, whatever its window holds.
- R9: An inbound BAR index B hits an inbound region that is enabled, in BAR-match mode and has BAR number B. The lowest index wins. One cycle later `ib_local_addr` = the region's 64-bit target and `ib_hit` = 1. Otherwise both are 0, and a region that is enabled but not in BAR-match mode never hits.
- R10: Offsets outside 0x900 to 0x91C read 0, and a write to them changes no register.
- R11: `reg_rdata` updates only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| ob_addr | input | 64 | Outbound local address |
| ob_bus_addr | output | 64 | Translated bus address (registered) |
| ob_kind | output | 3 | Transaction kind of the hit region: 0 memory, 2 IO, 4 config type 0, 5 config type 1 |
| ob_hit | output | 1 | Outbound window hit |
| ib_bar | input | 3 | BAR index of the inbound request |
| ib_local_addr | output | 64 | Local target address (registered) |
| ib_hit | output | 1 | Inbound BAR region hit |

## Verification
On every cycle the assertions check several invariants: the cleared outputs right after reset, pass-through of the address on an outbound miss, a zero inbound address on an inbound miss, no outbound hit while all outbound enables are clear, and read data that holds between read strobes. The remaining behaviour can only be shown by the bench's scenarios, run against a behavioural model that is compared every cycle. This covers the windowed register isolation between banks and regions, the field masking on readback, the offset arithmetic, the inclusive window edges, lowest-index priority under overlap, and BAR selection among duplicate BAR numbers.

// File: rtl/atu_pkg.sv
package atu_pkg;
  // register byte offsets; the viewport selector decides which region the
  // windowed offsets act on
  localparam logic [11:0] OFS_SEL  = 12'h900;
  localparam logic [11:0] OFS_KIND = 12'h904;
  localparam logic [11:0] OFS_CTL  = 12'h908;
  localparam logic [11:0] OFS_BLO  = 12'h90C;
  localparam logic [11:0] OFS_BHI  = 12'h910;
  localparam logic [11:0] OFS_LIM  = 12'h914;
  localparam logic [11:0] OFS_TLO  = 12'h918;
  localparam logic [11:0] OFS_THI  = 12'h91C;

  localparam int SEL_BANK_BIT = 31;
  localparam int CTL_EN_BIT   = 31;
  localparam int CTL_BM_BIT   = 30;
  localparam int CTL_BAR_LSB  = 8;
  localparam int BAR_W        = 3;
  localparam int KIND_W       = 3;

  typedef struct packed {
    logic              en;
    logic              barm;
    logic [BAR_W-1:0]  bar;
    logic [KIND_W-1:0] kind;
    logic [31:0]       blo;
    logic [31:0]       bhi;
    logic [31:0]       lim;
    logic [31:0]       tlo;
    logic [31:0]       thi;
  } rgn_t;
endpackage

// File: rtl/atu_regfile.sv
// Viewport register file: one selector plus a windowed view of the
// selected region. NREG must be a power of two.
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [11:0]                  addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  output logic [NREG-1:0]              ob_en,
  output logic [NREG-1:0][63:0]        ob_base,
  output logic [NREG-1:0][63:0]        ob_lim,
  output logic [NREG-1:0][63:0]        ob_tgt,
  output logic [NREG-1:0][KIND_W-1:0]  ob_kind,
  output logic [NREG-1:0]              ib_armed,
  output logic [NREG-1:0][BAR_W-1:0]   ib_barn,
  output logic [NREG-1:0][63:0]        ib_tgt
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  rgn_t [NREG-1:0] ob_q;
  rgn_t [NREG-1:0] ib_q;
  logic            sel_in;
  logic [IW-1:0]   sel_idx;
  rgn_t            cur;
  rgn_t            nxt;
  logic [31:0]     rd_mux;

  always_comb cur = sel_in ? ib_q[sel_idx] : ob_q[sel_idx];

  always_comb begin
    nxt = cur;
    unique case (addr)
      OFS_KIND: nxt.kind = wdata[KIND_W-1:0];
      OFS_CTL: begin
        nxt.en   = wdata[CTL_EN_BIT];
        nxt.barm = wdata[CTL_BM_BIT];
        nxt.bar  = wdata[CTL_BAR_LSB +: BAR_W];
      end
      OFS_BLO: nxt.blo = wdata;
      OFS_BHI: nxt.bhi = wdata;
      OFS_LIM: nxt.lim = wdata;
      OFS_TLO: nxt.tlo = wdata;
      OFS_THI: nxt.thi = wdata;
      default: ;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFS_SEL: begin
        rd_mux[SEL_BANK_BIT] = sel_in;
        rd_mux[IW-1:0]       = sel_idx;
      end
      OFS_KIND: rd_mux[KIND_W-1:0] = cur.kind;
      OFS_CTL: begin
        rd_mux[CTL_EN_BIT]              = cur.en;
        rd_mux[CTL_BM_BIT]              = cur.barm;
        rd_mux[CTL_BAR_LSB +: BAR_W]    = cur.bar;
      end
      OFS_BLO: rd_mux = cur.blo;
      OFS_BHI: rd_mux = cur.bhi;
      OFS_LIM: rd_mux = cur.lim;
      OFS_TLO: rd_mux = cur.tlo;
      OFS_THI: rd_mux = cur.thi;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_in  <= 1'b0;
      sel_idx <= '0;
      ob_q    <= '0;
      ib_q    <= '0;
      rdata   <= '0;
    end else begin
      if (wr) begin
        if (addr == OFS_SEL) begin
          sel_in  <= wdata[SEL_BANK_BIT];
          sel_idx <= wdata[IW-1:0];
        end else if (sel_in) begin
          ib_q[sel_idx] <= nxt;
        end else begin
          ob_q[sel_idx] <= nxt;
        end
      end
      if (rd) rdata <= rd_mux;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign ob_en[g]    = ob_q[g].en;
    assign ob_base[g]  = {ob_q[g].bhi, ob_q[g].blo};
    assign ob_lim[g]   = {ob_q[g].bhi, ob_q[g].lim};
    assign ob_tgt[g]   = {ob_q[g].thi, ob_q[g].tlo};
    assign ob_kind[g]  = ob_q[g].kind;
    assign ib_armed[g] = ib_q[g].en & ib_q[g].barm;
    assign ib_barn[g]  = ib_q[g].bar;
    assign ib_tgt[g]   = {ib_q[g].thi, ib_q[g].tlo};
  end
endmodule

// File: rtl/atu_ob_match.sv
// Outbound range compare, offset add and lowest-index priority.
module atu_ob_match
  import atu_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             en,
  input  logic [NREG-1:0][63:0]       base,
  input  logic [NREG-1:0][63:0]       lim,
  input  logic [NREG-1:0][63:0]       tgt,
  input  logic [NREG-1:0][KIND_W-1:0] kind,
  input  logic [63:0]                 addr,
  output logic [63:0]                 bus_addr,
  output logic [KIND_W-1:0]           kind_o,
  output logic                        hit
);
  logic [NREG-1:0]       inwin;
  logic [NREG-1:0][63:0] xl;
  logic [63:0]           n_addr;
  logic [KIND_W-1:0]     n_kind;
  logic                  n_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign inwin[g] = en[g] && (addr >= base[g]) && (addr <= lim[g]);
    assign xl[g]    = tgt[g] + (addr - base[g]);
  end

  always_comb begin
    n_addr = addr;
    n_kind = '0;
    n_hit  = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (inwin[i]) begin
        n_addr = xl[i];
        n_kind = kind[i];
        n_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      kind_o   <= '0;
      hit      <= 1'b0;
    end else begin
      bus_addr <= n_addr;
      kind_o   <= n_kind;
      hit      <= n_hit;
    end
  end
endmodule

// File: rtl/atu_ib_match.sv
// Inbound BAR-number match with lowest-index priority.
module atu_ib_match
  import atu_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREG-1:0]            armed,
  input  logic [NREG-1:0][BAR_W-1:0] barn,
  input  logic [NREG-1:0][63:0]      tgt,
  input  logic [BAR_W-1:0]           bar,
  output logic [63:0]                local_addr,
  output logic                       hit
);
  logic [NREG-1:0] sel;
  logic [63:0]     n_addr;
  logic            n_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_bar
    assign sel[g] = armed[g] && (barn[g] == bar);
  end

  always_comb begin
    n_addr = '0;
    n_hit  = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (sel[i]) begin
        n_addr = tgt[i];
        n_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      local_addr <= '0;
      hit        <= 1'b0;
    end else begin
      local_addr <= n_addr;
      hit        <= n_hit;
    end
  end
endmodule

// File: rtl/atu_window.sv
module atu_window
  import atu_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       ob_addr,
  output logic [63:0]       ob_bus_addr,
  output logic [2:0]        ob_kind,
  output logic              ob_hit,
  input  logic [2:0]        ib_bar,
  output logic [63:0]       ib_local_addr,
  output logic              ib_hit
);
  logic [NREG-1:0]             ob_en_vec;
  logic [NREG-1:0][63:0]       ob_base;
  logic [NREG-1:0][63:0]       ob_lim;
  logic [NREG-1:0][63:0]       ob_tgt;
  logic [NREG-1:0][KIND_W-1:0] ob_kinds;
  logic [NREG-1:0]             ib_armed;
  logic [NREG-1:0][BAR_W-1:0]  ib_barn;
  logic [NREG-1:0][63:0]       ib_tgt;

  atu_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ob_en(ob_en_vec), .ob_base(ob_base), .ob_lim(ob_lim), .ob_tgt(ob_tgt),
    .ob_kind(ob_kinds), .ib_armed(ib_armed), .ib_barn(ib_barn), .ib_tgt(ib_tgt)
  );

  atu_ob_match #(.NREG(NREG)) u_ob (
    .clk(clk), .rst(rst), .en(ob_en_vec), .base(ob_base), .lim(ob_lim),
    .tgt(ob_tgt), .kind(ob_kinds), .addr(ob_addr),
    .bus_addr(ob_bus_addr), .kind_o(ob_kind), .hit(ob_hit)
  );

  atu_ib_match #(.NREG(NREG)) u_ib (
    .clk(clk), .rst(rst), .armed(ib_armed), .barn(ib_barn), .tgt(ib_tgt),
    .bar(ib_bar), .local_addr(ib_local_addr), .hit(ib_hit)
  );
endmodule

// File: rtl/atu_window_chk.sv
module atu_window_chk #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_rd,
  input logic [31:0]     reg_rdata,
  input logic [63:0]     ob_addr,
  input logic [63:0]     ob_bus_addr,
  input logic [2:0]      ob_kind,
  input logic            ob_hit,
  input logic [63:0]     ib_local_addr,
  input logic            ib_hit,
  input logic [NREG-1:0] ob_en_vec
);
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ob_hit && !ib_hit && reg_rdata == 32'd0 && ib_local_addr == 64'd0)); // R1

  AST_MISS_PASSES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ob_hit) |-> (ob_bus_addr == $past(ob_addr) && ob_kind == 3'd0)); // R6

  AST_NO_EN_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ob_en_vec) == '0) |-> !ob_hit); // R8

  AST_IB_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ib_hit |-> ib_local_addr == 64'd0); // R9

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rd)) |-> $stable(reg_rdata)); // R11
endmodule

bind atu_window atu_window_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .ob_addr(ob_addr), .ob_bus_addr(ob_bus_addr), .ob_kind(ob_kind),
  .ob_hit(ob_hit), .ib_local_addr(ib_local_addr), .ib_hit(ib_hit),
  .ob_en_vec(ob_en_vec)
);

// File: tb/sim_atu_window.sv
`timescale 1ns/1ps
module sim_atu_window;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] ob_addr = '0;
  logic [63:0] ob_bus_addr;
  logic [2:0]  ob_kind;
  logic        ob_hit;
  logic [2:0]  ib_bar = '0;
  logic [63:0] ib_local_addr;
  logic        ib_hit;

  atu_window #(.NREG(NR)) u0 (.*);

  always #5 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    armed = 0, done = 0;
  string tag = "R1";

  // behavioural model: bank 0 outbound, bank 1 inbound
  logic        m_en[2][NR], m_bm[2][NR];
  logic [2:0]  m_bar[2][NR], m_kind[2][NR];
  logic [31:0] m_blo[2][NR], m_bhi[2][NR], m_lim[2][NR], m_tlo[2][NR], m_thi[2][NR];
  int          m_bank, m_idx;
  logic [31:0] e_rd;
  logic [63:0] e_oba, e_iba;
  logic [2:0]  e_obk;
  logic        e_obh, e_ibh;

  function automatic logic [31:0] mread(input logic [11:0] a);
    int b = m_bank, i = m_idx;
    case (a)
      12'h900: return {m_bank[0], 29'd0, m_idx[1:0]};
      12'h904: return {29'd0, m_kind[b][i]};
      12'h908: return {m_en[b][i], m_bm[b][i], 19'd0, m_bar[b][i], 8'd0};
      12'h90C: return m_blo[b][i];
      12'h910: return m_bhi[b][i];
      12'h914: return m_lim[b][i];
      12'h918: return m_tlo[b][i];
      12'h91C: return m_thi[b][i];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_bank = 0; m_idx = 0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NR; i++) begin
          m_en[b][i] = 0; m_bm[b][i] = 0; m_bar[b][i] = 0; m_kind[b][i] = 0;
          m_blo[b][i] = 0; m_bhi[b][i] = 0; m_lim[b][i] = 0; m_tlo[b][i] = 0; m_thi[b][i] = 0;
        end
      e_rd = 0; e_oba = 0; e_obk = 0; e_obh = 0; e_iba = 0; e_ibh = 0;
    end else begin
      if (reg_rd) e_rd = mread(reg_addr);
      e_obh = 0; e_oba = ob_addr; e_obk = 0;
      for (int i = 0; i < NR; i++) begin
        logic [63:0] bs, lm;
        bs = {m_bhi[0][i], m_blo[0][i]};
        lm = {m_bhi[0][i], m_lim[0][i]};
        if (!e_obh && m_en[0][i] && ob_addr >= bs && ob_addr <= lm) begin
          e_obh = 1; e_oba = {m_thi[0][i], m_tlo[0][i]} + (ob_addr - bs); e_obk = m_kind[0][i];
        end
      end
      e_ibh = 0; e_iba = 0;
      for (int i = 0; i < NR; i++)
        if (!e_ibh && m_en[1][i] && m_bm[1][i] && m_bar[1][i] == ib_bar) begin
          e_ibh = 1; e_iba = {m_thi[1][i], m_tlo[1][i]};
        end
      if (reg_wr) begin
        case (reg_addr)
          12'h900: begin m_bank = int'(reg_wdata[31]); m_idx = int'(reg_wdata[1:0]); end
          12'h904: m_kind[m_bank][m_idx] = reg_wdata[2:0];
          12'h908: begin
            m_en[m_bank][m_idx] = reg_wdata[31]; m_bm[m_bank][m_idx] = reg_wdata[30];
            m_bar[m_bank][m_idx] = reg_wdata[10:8];
          end
          12'h90C: m_blo[m_bank][m_idx] = reg_wdata;
          12'h910: m_bhi[m_bank][m_idx] = reg_wdata;
          12'h914: m_lim[m_bank][m_idx] = reg_wdata;
          12'h918: m_tlo[m_bank][m_idx] = reg_wdata;
          12'h91C: m_thi[m_bank][m_idx] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !rst) begin
      chk("reg_rdata", {32'd0, reg_rdata}, {32'd0, e_rd});
      chk("ob_bus_addr", ob_bus_addr, e_oba);
      chk("ob_kind/hit", {60'd0, ob_kind, ob_hit}, {60'd0, e_obk, e_obh});
      chk("ib_local_addr/hit", ib_local_addr ^ {63'd0, ib_hit}, e_iba ^ {63'd0, e_ibh});
      chk("ib_hit", {63'd0, ib_hit}, {63'd0, e_ibh});
    end
  end

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [11:0] a);
    @(negedge clk); reg_wr = 0; reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic probe(input logic [63:0] oa, input logic [2:0] b);
    @(negedge clk); reg_wr = 0; reg_rd = 0; ob_addr = oa; ib_bar = b;
  endtask

  task automatic sel(input bit inb, input int idx);
    wreg(12'h900, {inb, 29'd0, idx[1:0]});
  endtask

  task automatic prog(input logic [31:0] blo, bhi, lim, tlo, thi,
                      input logic [2:0] kind, input logic [31:0] ctl);
    wreg(12'h90C, blo); wreg(12'h910, bhi); wreg(12'h914, lim);
    wreg(12'h918, tlo); wreg(12'h91C, thi); wreg(12'h904, {29'd0, kind});
    wreg(12'h908, ctl);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; armed = 1;
    // R1: reset state of every register in both banks
    tag = "R1";
    probe(64'h0000_0004_1000_0000, 3'd0);
    rreg(12'h900);
    for (int a = 12'h904; a <= 12'h91C; a += 4) rreg(12'(a));
    sel(1, 3);
    for (int a = 12'h904; a <= 12'h91C; a += 4) rreg(12'(a));
    // R2: selector readback with masking
    tag = "R2";
    wreg(12'h900, 32'h8000_0002); rreg(12'h900);
    wreg(12'h900, 32'hFFFF_FFFF); rreg(12'h900);
    wreg(12'h900, 32'h7FFF_FFF1); rreg(12'h900);
    // R3: windowed access, field masks and isolation between regions/banks
    tag = "R3";
    sel(0, 0);
    prog(32'h1000_0000, 32'h4, 32'h1000_FFFF, 32'h0108_0000, 32'h0, 3'd4, 32'h8000_0000);
    sel(0, 1);
    prog(32'h4000_0000, 32'h0, 32'h4FFF_FFFF, 32'hAAAA_0000, 32'h5, 3'd2, 32'h0);
    wreg(12'h904, 32'hFFFF_FFFF); rreg(12'h904);
    wreg(12'h908, 32'h3FFF_F7FF); rreg(12'h908);
    wreg(12'h908, 32'h0000_0000);
    sel(1, 1); wreg(12'h90C, 32'hDEAD_BEEF);
    sel(0, 0);
    for (int a = 12'h904; a <= 12'h91C; a += 4) rreg(12'(a));
    sel(0, 1); rreg(12'h90C); rreg(12'h918);
    sel(1, 1); rreg(12'h90C); sel(1, 0); rreg(12'h90C);
    // R10: unmapped offsets
    tag = "R10";
    sel(0, 1);
    wreg(12'h920, 32'h1234_5678); wreg(12'h8FC, 32'hFFFF_FFFF); wreg(12'h000, 32'h8000_0003);
    rreg(12'h920); rreg(12'h8FC); rreg(12'h900); rreg(12'h90C);
    // R4: translation including upper address and config target
    tag = "R4";
    probe(64'h0000_0004_1000_0123, 3'd0);
    probe(64'h0000_0004_1000_8000, 3'd0);
    sel(0, 2);
    prog(32'h8000_0000, 32'h0, 32'h8FFF_FFFF, 32'h2345_0000, 32'h1, 3'd0, 32'h8000_0000);
    probe(64'h0000_0000_8123_4567, 3'd0);
    // R5: inclusive edges
    tag = "R5";
    probe(64'h0000_0000_7FFF_FFFF, 3'd0);
    probe(64'h0000_0000_8000_0000, 3'd0);
    probe(64'h0000_0000_8FFF_FFFF, 3'd0);
    probe(64'h0000_0000_9000_0000, 3'd0);
    probe(64'h0000_0004_0FFF_FFFF, 3'd0);
    probe(64'h0000_0004_1001_0000, 3'd0);
    probe(64'h0000_0005_1000_0000, 3'd0);
    // R6: misses pass the address through
    tag = "R6";
    probe(64'hFFFF_0000_1234_5678, 3'd0);
    probe(64'h0, 3'd0);
    // R7: overlap, lowest index wins
    tag = "R7";
    sel(0, 3);
    prog(32'h8800_0000, 32'h0, 32'h9FFF_FFFF, 32'h0, 32'h0, 3'd2, 32'h8000_0000);
    probe(64'h0000_0000_8800_0010, 3'd0);
    probe(64'h0000_0000_9800_0000, 3'd0);
    // R8: disabled regions never match
    tag = "R8";
    probe(64'h0000_0000_4000_0100, 3'd0);
    sel(0, 2); wreg(12'h908, 32'h0);
    probe(64'h0000_0000_8800_0010, 3'd0);
    probe(64'h0000_0000_8100_0000, 3'd0);
    // R9: inbound BAR match, duplicates and non-BAR-mode regions
    tag = "R9";
    sel(1, 0); prog(32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 3'd0, 32'hC000_0000);
    sel(1, 1); prog(32'h0, 32'h0, 32'h0, 32'h8000_2000, 32'h0, 3'd0, 32'hC000_0100);
    sel(1, 2); prog(32'h0, 32'h0, 32'h0, 32'h9999_0000, 32'h7, 3'd0, 32'hC000_0100);
    sel(1, 3); prog(32'h0, 32'h0, 32'hFFFF_FFFF, 32'h8010_0000, 32'h0, 3'd0, 32'h8000_0400);
    for (int b = 0; b < 8; b++) probe(64'h0, 3'(b));
    sel(1, 1); wreg(12'h908, 32'h0);
    probe(64'h0, 3'd1);
    sel(1, 3); wreg(12'h908, 32'hC000_0400);
    probe(64'h0, 3'd4);
    // R11: read data holds between strobes
    tag = "R11";
    sel(0, 0); rreg(12'h918);
    wreg(12'h918, 32'h0);
    probe(64'h1, 3'd2); probe(64'h2, 3'd3);
    rreg(12'h918);
    repeat (3) probe(64'h0, 3'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule